// File: doc/BRIEF.md
# I2C Register-Port Target with Autoincrement and Interrupt Status

This block is an I2C target that gives an external controller access to a 128-entry register space. SCL and SDA are sampled in the system clock domain. SDA is open-drain: the block never drives a high level. It only raises an enable that pulls the line low. The target answers one fixed 7-bit address. In a write transaction, the first byte after the address is a pointer byte. Bit 7 of that byte enables autoincrement and bits 6:0 select the register. Each following data byte is written at the pointer.

A read transaction returns bytes starting at the stored pointer. A controller that sends only the pointer byte and then STOP leaves every register unchanged, but the new pointer stays in place for the next read. Two addresses are held inside the block:

- The interrupt mask register.
- The interrupt status register. Event inputs set its bits, and a read that the controller acknowledges clears them.

The interrupt output is high while any status bit is set and not masked. All other addresses are forwarded to a register file outside the block. Writes leave on a valid/ready port and reads use a plain combinational address/data port.

Write-port back-pressure: `wr_valid_o` rises after a data byte is received. Address and data stay stable while valid is high and ready is low. The transfer completes in the first cycle where both are high. The register file must accept the transfer before the next data byte completes, which is at least eight SCL periods later. A newer byte replaces a transfer that is still pending at that point.

Top module: `i2c_rp_top`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits are 1001010 (so 0x94 selects write and 0x95 selects read) by holding SDA low through the ninth SCL pulse. For any other address it leaves SDA released and acknowledges no byte until the next START.
- R2: In a write, the first byte after the address is the pointer byte, where bit 7 is the autoincrement enable and bits 6:0 are the register address. Every later data byte is acknowledged and written at the pointer. For external addresses the write appears on the write port with that address and that data.
- R3: With autoincrement set, the pointer advances by one after each data byte that is written or acknowledged on a read, and 0x7F wraps to 0x00. With autoincrement clear, the pointer does not move, so repeated bytes use the same register.
- R4: A STOP right after the pointer byte writes no register, and the next read starts at that pointer.
- R5: A read sends the byte at the pointer MSB first. After a controller ACK it sends the next byte. After a NACK it keeps SDA released until the next START.
- R6: On the write port, `wr_addr_o` and `wr_data_o` hold steady while `wr_valid_o` is high and `wr_ready_i` is low. Valid drops after the handshake cycle.
- R7: The mask register at 0x35 is held inside the block and is never forwarded to the write port. It reads back what was last written and resets to all ones, where a 1 masks that bit.
- R8: The status register at 0x36 is held inside the block. An event input high sets its bit. Writes to it are ignored and are not forwarded. A read of 0x36 clears the bits that were sent, but only once the controller has acknowledged the byte; a NACK leaves them set. If an event arrives in the same cycle as the clear, the event wins.
- R9: `irq_o` is high exactly while some status bit is 1 and its mask bit is 0.
- R10: After reset, SDA is released, `irq_o` is low and `wr_valid_o` is low.
- R11: The SDA drive enable changes only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| irq_o | output | 1 | Active-high interrupt |
| evt_i | input | EVT_W | Event inputs that set status bits |
| wr_valid_o | output | 1 | Register-file write request |
| wr_ready_i | input | 1 | Register file accepts the write |
| wr_addr_o | output | 7 | Write address |
| wr_data_o | output | 8 | Write data |
| rd_addr_o | output | 7 | Read address (current pointer) |
| rd_data_i | input | 8 | Register-file data at `rd_addr_o` |

## Verification
The bench builds the block with its defaults: address 1001010, an eight-bit event vector and two synchronizer stages. The full eight-bit status and mask let the bench hold one event masked while another is unmasked, and then release the mask so that a latched event raises the interrupt. With the seven-bit pointer, a three-byte autoincrement burst that starts at 0x7E reaches the wrap from 0x7F to 0x00. The bench holds write-ready low in two of every three cycles, so the write port is checked under back-pressure.

// File: rtl/i2c_rp_pkg.sv
`timescale 1ns/1ps
package i2c_rp_pkg;
  localparam int AW = 7;
  localparam int DW = 8;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_MAP, ST_MAP_ACK,
    ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_RNEXT
  } rp_state_e;
endpackage

// File: rtl/i2c_rp_sync.sv
`timescale 1ns/1ps
module i2c_rp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign dout = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/i2c_rp_irq.sv
`timescale 1ns/1ps
module i2c_rp_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] status_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      if (clr_en) status_q <= (status_q & ~clr_bits) | evt_i;
      else        status_q <= status_q | evt_i;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);

  // R8: an event is latched in the next cycle, even when a clear is under way
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));
  // R8: bits that were read out are gone after an acknowledged read
  a_r8_clear_sent: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && evt_i == '0) |=> ((status_q & $past(clr_bits)) == '0));
  // R7: the mask changes only through a mask write
  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/i2c_rp_top.sv
`timescale 1ns/1ps
module i2c_rp_top
  import i2c_rp_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1001010,
  parameter logic [6:0] MASK_ADDR   = 7'h35,
  parameter logic [6:0] STAT_ADDR   = 7'h36,
  parameter int         EVT_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic             irq_o,
  input  logic [EVT_W-1:0] evt_i,
  output logic             wr_valid_o,
  input  logic             wr_ready_i,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [DW-1:0]    rd_data_i
);
  logic scl_s, scl_rise, scl_fall, sda_s, sda_rise, sda_fall;

  i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .din(scl_i),
    .dout(scl_s), .rise(scl_rise), .fall(scl_fall));
  i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .din(sda_i),
    .dout(sda_s), .rise(sda_rise), .fall(sda_fall));

  wire bus_start = scl_s & sda_fall;
  wire bus_stop  = scl_s & sda_rise;

  rp_state_e     state;
  logic [3:0]    bitcnt;
  logic [DW-1:0] shreg, rd_byte, wr_data_q;
  logic [AW-1:0] ptr, wr_addr_q;
  logic          ai, rw, ack_on, oe, wr_valid_q, clr_en, mask_we;
  logic [EVT_W-1:0] status_v, mask_v;
  logic [DW-1:0] status_b, mask_b, rd_mux;

  i2c_rp_irq #(.W(EVT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .mask_we(mask_we), .mask_wdata(shreg[EVT_W-1:0]),
    .clr_en(clr_en), .clr_bits(rd_byte[EVT_W-1:0]),
    .status_o(status_v), .mask_o(mask_v), .irq_o(irq_o));

  always_comb begin
    status_b = '0;
    mask_b   = '0;
    status_b[EVT_W-1:0] = status_v;
    mask_b[EVT_W-1:0]   = mask_v;
    if (ptr == MASK_ADDR)      rd_mux = mask_b;
    else if (ptr == STAT_ADDR) rd_mux = status_b;
    else                       rd_mux = rd_data_i;
  end

  wire [DW-1:0] byte_in = {shreg[DW-2:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  bitcnt <= '0;  shreg <= '0;  rd_byte <= '0;
      ptr <= '0;  ai <= 1'b0;  rw <= 1'b0;  ack_on <= 1'b0;  oe <= 1'b0;
      wr_valid_q <= 1'b0;  wr_addr_q <= '0;  wr_data_q <= '0;
      clr_en <= 1'b0;  mask_we <= 1'b0;
    end else begin
      clr_en  <= 1'b0;
      mask_we <= 1'b0;
      if (wr_valid_q && wr_ready_i) wr_valid_q <= 1'b0;
      if (bus_start) begin
        state <= ST_ADDR;  bitcnt <= '0;  oe <= 1'b0;  ack_on <= 1'b0;
      end else if (bus_stop) begin
        state <= ST_IDLE;  oe <= 1'b0;  ack_on <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_MAP, ST_WDATA: if (scl_rise) begin
            shreg  <= byte_in;
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (byte_in[7:1] == DEV_ADDR) begin
                  rw <= byte_in[0];  state <= ST_ADDR_ACK;
                end else state <= ST_IDLE;
              end else if (state == ST_MAP) begin
                ai <= byte_in[7];  ptr <= byte_in[6:0];  state <= ST_MAP_ACK;
              end else begin
                if (ptr == MASK_ADDR) mask_we <= 1'b1;
                else if (ptr != STAT_ADDR) begin
                  wr_valid_q <= 1'b1;  wr_addr_q <= ptr;  wr_data_q <= byte_in;
                end
                if (ai) ptr <= ptr + 7'd1;
                state <= ST_WACK;
              end
            end
          end
          ST_ADDR_ACK, ST_MAP_ACK, ST_WACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;  oe <= 1'b1;
            end else begin
              ack_on <= 1'b0;  oe <= 1'b0;
              if (state == ST_ADDR_ACK && rw) begin
                rd_byte <= rd_mux;  shreg <= rd_mux;  oe <= ~rd_mux[7];
                bitcnt <= '0;  state <= ST_RDATA;
              end else if (state == ST_ADDR_ACK) state <= ST_MAP;
              else state <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) oe <= ~shreg[7];
            if (scl_rise) begin
              shreg  <= {shreg[DW-2:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
              if (bitcnt == 4'd7) begin
                bitcnt <= '0;  state <= ST_RACK;
              end
            end
          end
          ST_RACK: begin
            if (scl_fall) oe <= 1'b0;
            if (scl_rise) begin
              if (!sda_s) begin
                if (ptr == STAT_ADDR) clr_en <= 1'b1;
                if (ai) ptr <= ptr + 7'd1;
                state <= ST_RNEXT;
              end else state <= ST_IDLE;
            end
          end
          ST_RNEXT: if (scl_fall) begin
            rd_byte <= rd_mux;  shreg <= rd_mux;  oe <= ~rd_mux[7];
            bitcnt <= '0;  state <= ST_RDATA;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe;
  assign wr_valid_o = wr_valid_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign rd_addr_o  = ptr;

  // R11: the drive enable moves only while SCL is low
  a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe) |-> !scl_s);
  // R1: an idle target never pulls SDA
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !oe);
  // R6: a stalled write holds address and data
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_q && !wr_ready_i) |=> (wr_valid_q && $stable(wr_addr_q) && $stable(wr_data_q)));
  // R7: internal addresses never reach the write port
  a_r7_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_q |-> (wr_addr_q != MASK_ADDR && wr_addr_q != STAT_ADDR));
endmodule

// File: tb/i2c_rp_top_tb_top.sv
`timescale 1ns/1ps
module i2c_rp_top_tb_top;
  localparam int Q = 10;
  localparam int NV = 4;
  localparam logic [14:0] VEC [NV] = '{
    {7'h05, 8'hA5}, {7'h10, 8'h3C}, {7'h34, 8'hFF}, {7'h37, 8'h5A}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, host_sda = 1'b1;
  logic sda_oe, irq, wr_valid, wr_ready = 1'b0;
  logic [7:0] evt = '0;
  logic [6:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] mem [128];
  int total = 0, fails = 0, wr_count = 0, cyc = 0;
  logic fwd_internal = 1'b0, oe_viol = 1'b0, prev_oe = 1'b0, prev_scl = 1'b1;

  wire sda_line = host_sda & ~sda_oe;
  assign rd_data = mem[rd_addr];

  always #2.5 clk = ~clk;

  i2c_rp_top dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .irq_o(irq), .evt_i(evt),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data));

  initial for (int i = 0; i < 128; i++) mem[i] = 8'h00;

  always @(posedge clk) if (rst_n && wr_valid && wr_ready) begin
    mem[wr_addr] <= wr_data;
    wr_count <= wr_count + 1;
    if (wr_addr == 7'h35 || wr_addr == 7'h36) fwd_internal <= 1'b1;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    wr_ready <= (cyc % 3) == 0;
    if (rst_n && sda_oe != prev_oe && prev_scl && scl) oe_viol <= 1'b1;
    prev_oe <= sda_oe;
    prev_scl <= scl;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; w(Q); scl = 1'b1; w(Q); host_sda = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; w(Q); scl = 1'b1; w(Q); host_sda = 1'b1; w(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
    end
    host_sda = 1'b1; w(Q); scl = 1'b1; w(Q); nack = sda_line; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic rbyte(input logic do_ack, output logic [7:0] d);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl = 1'b1; w(Q); d[i] = sda_line; w(Q); scl = 1'b0; w(Q);
    end
    host_sda = ~do_ack; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q); host_sda = 1'b1;
  endtask

  task automatic write_reg(input logic [7:0] map, input logic [7:0] d, input string tag);
    logic n;
    bus_start();
    wbyte(8'h94, n); chk({tag, " addr ack"}, n, 1'b0);
    wbyte(map, n);   chk({tag, " map ack"}, n, 1'b0);
    wbyte(d, n);     chk({tag, " data ack"}, n, 1'b0);
    bus_stop(); w(8);
  endtask

  task automatic set_ptr(input logic [7:0] map);
    logic n;
    bus_start(); wbyte(8'h94, n); wbyte(map, n); bus_stop(); w(4);
  endtask

  task automatic read_one(output logic [7:0] d);
    logic n;
    bus_start(); wbyte(8'h95, n); rbyte(1'b0, d); bus_stop(); w(4);
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk); evt = e; @(negedge clk); evt = '0; w(4);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d, d2, d3;
    logic n;
    int wc;
    w(10);
    chk("R10 sda released", sda_oe, 1'b0);
    chk("R10 irq low", irq, 1'b0);
    chk("R10 wr_valid low", wr_valid, 1'b0);
    rst_n = 1'b1; w(10);
    chk("R10 after reset oe", sda_oe, 1'b0);

    for (int v = 0; v < NV; v++) begin
      write_reg({1'b0, VEC[v][14:8]}, VEC[v][7:0], "R1 R2 vector");
      chk("R2 R6 file holds data", mem[VEC[v][14:8]], VEC[v][7:0]);
      set_ptr({1'b0, VEC[v][14:8]});
      read_one(d);
      chk("R4 R5 vector readback", d, VEC[v][7:0]);
    end

    wc = wr_count;
    bus_start();
    wbyte(8'h92, n); chk("R1 wrong address no ack", n, 1'b1);
    wbyte(8'h05, n); chk("R1 stays idle", n, 1'b1);
    bus_stop(); w(8);
    chk("R1 no write on mismatch", wr_count, wc);

    bus_start(); wbyte(8'h94, n); wbyte(8'hFE, n);
    wbyte(8'h11, n); wbyte(8'h22, n); wbyte(8'h33, n); bus_stop(); w(8);
    chk("R3 burst at 7E", mem[7'h7E], 8'h11);
    chk("R3 burst at 7F", mem[7'h7F], 8'h22);
    chk("R3 burst wraps to 00", mem[7'h00], 8'h33);

    wc = wr_count;
    set_ptr(8'hFE);
    chk("R4 aborted write changes nothing", wr_count, wc);
    bus_start(); wbyte(8'h95, n);
    rbyte(1'b1, d); rbyte(1'b1, d2); rbyte(1'b0, d3);
    chk("R5 oe released after nack", sda_oe, 1'b0);
    bus_stop(); w(4);
    chk("R3 R5 burst read 7E", d, 8'h11);
    chk("R3 R5 burst read 7F", d2, 8'h22);
    chk("R3 R5 burst read wraps", d3, 8'h33);

    set_ptr(8'h7E);
    bus_start(); wbyte(8'h95, n); rbyte(1'b1, d); rbyte(1'b0, d2); bus_stop(); w(4);
    chk("R3 no autoincrement first", d, 8'h11);
    chk("R3 no autoincrement repeat", d2, 8'h11);

    set_ptr(8'h35); read_one(d);
    chk("R7 mask reset value", d, 8'hFF);
    write_reg(8'h35, 8'hFE, "R7 mask write");
    set_ptr(8'h35); read_one(d);
    chk("R7 mask readback", d, 8'hFE);

    pulse(8'h02);
    chk("R9 masked event keeps irq low", irq, 1'b0);
    pulse(8'h01);
    chk("R9 unmasked event raises irq", irq, 1'b1);
    write_reg(8'h36, 8'h00, "R8 status write");
    chk("R8 R7 internal not forwarded", fwd_internal, 1'b0);
    set_ptr(8'h36); read_one(d);
    chk("R8 status after ignored write, nack read", d, 8'h03);
    chk("R8 nack read does not clear", irq, 1'b1);
    bus_start(); wbyte(8'h95, n); rbyte(1'b1, d); rbyte(1'b0, d2); bus_stop(); w(4);
    chk("R8 status read", d, 8'h03);
    chk("R8 cleared after ack", d2, 8'h00);
    chk("R9 irq low after clear", irq, 1'b0);
    pulse(8'h80);
    chk("R9 bit7 masked", irq, 1'b0);
    write_reg(8'h35, 8'h7E, "R7 unmask bit7");
    chk("R9 unmask latched event", irq, 1'b1);

    chk("R11 oe changed only with scl low", oe_viol, 1'b0);
    finish_run();
  end
endmodule